// File: doc/BRIEF.md
# Serial Gain Word Loader

This block is the control port in front of a programmable attenuator. A host sends an 8-bit gain word over three wires: a data line, a serial clock, and an active-low enable strobe. The word goes into a two-stage shift register in which each bit moves on both edges of the serial clock. The rising edge takes the bit into an entry stage. The falling edge pushes that bit into the word register. When the enable strobe rises, the assembled word is copied into a parallel gain register that feeds the attenuator, and shifting stops. A separate active-low power-down input decides whether the output amplifier is enabled.

The serial clock, serial data, strobe and power-down inputs are slow, asynchronous signals. They are resampled into a fast system clock through a two-stage synchronizer. Edges are then detected from the synchronized levels. The serial data line passes through the same delay, so each data bit stays aligned with the clock edge that captures it.

Top module: `gain_word_loader`

## Requirements
- R1: The gain word is 8 bits and arrives most significant bit first. After eight complete serial clock cycles with the strobe low, followed by a strobe rise, `gain_code` equals the eight bits in the order sent, with the first bit sent in bit 7.
- R2: A rising serial clock edge while the strobe is low only captures the data bit into the entry stage. If no falling edge follows before the strobe rises, the committed word does not contain that bit.
- R3: A falling serial clock edge while the strobe is low shifts the word register left by one and places the entry-stage bit in bit 0.
- R4: `gain_code` keeps its value in every cycle in which no strobe rise is being committed, including the whole time serial data is being shifted with the strobe low.
- R5: A rise of `load_en_n` copies the word register into `gain_code`. The new value is visible after the third rising system clock edge that samples the strobe high.
- R6: While the synchronized strobe is high, serial clock edges are ignored: they neither capture nor shift.
- R7: `gain_upd` is high for exactly one cycle per strobe rise. It is high in the same cycle in which `gain_code` first shows the newly loaded word.
- R8: `amp_en` follows `pwr_dn_n` two system clock edges after it changes: 1 enables the output amplifier, 0 disables it.
- R9: An asynchronous reset (`rst_n` low) clears the word register and `gain_code` to 0x00 and drives `gain_upd` and `amp_en` low.
- R10: If the strobe rises after fewer than eight shifts, the current word register contents are loaded anyway, and nothing signals the short word.
- R11: If the strobe rise and a serial clock fall reach the synchronized domain in the same cycle, the strobe takes priority. That shift is dropped, and the word is committed without it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_data | input | 1 | Serial gain data, MSB first |
| ser_clk | input | 1 | Serial clock: rise captures, fall shifts |
| load_en_n | input | 1 | Active-low enable strobe; its rise commits the word |
| pwr_dn_n | input | 1 | Active-low power-down |
| gain_code | output | 8 | Parallel gain code for the attenuator |
| gain_upd | output | 1 | One-cycle pulse when gain_code is loaded |
| amp_en | output | 1 | Output amplifier enable |

## Verification
Two functions can fall in the same synchronized cycle: a strobe rise that commits the word and a serial clock fall that would shift it. The bench provokes this by driving both input changes at the same clock edge, so that they pass through the synchronizer together. The result is judged by committing the word and checking that it equals the word before the dropped shift. A second commit then checks that the captured bit never reached the word register. A queue-based reference model compares `gain_code`, `gain_upd` and `amp_en` on every clock, which also covers randomly spaced words.

// File: rtl/gwl_pkg.sv
package gwl_pkg;
  // Positions of the asynchronous inputs inside the synchronizer vector
  localparam int unsigned IDX_DATA = 0;
  localparam int unsigned IDX_SCLK = 1;
  localparam int unsigned IDX_DEN  = 2;
  localparam int unsigned IDX_PD   = 3;
  localparam int unsigned CTL_W    = 4;

  localparam int unsigned GAIN_W_DEF = 8;
  localparam int unsigned SYNC_DEF   = 2;
endpackage

// File: rtl/gwl_sync.sv
module gwl_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gwl_hist.sv
module gwl_hist #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] prev
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end
endmodule

// File: rtl/gwl_shift.sv
module gwl_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic         adv,
  input  logic         din,
  output logic         master_q,
  output logic [W-1:0] slave_q
);
  function automatic logic [W-1:0] shift_in(input logic [W-1:0] word, input logic b);
    return {word[W-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      slave_q  <= '0;
    end else begin
      if (cap) master_q <= din;
      if (adv) slave_q  <= shift_in(slave_q, master_q);
    end
  end
endmodule

// File: rtl/gain_word_loader.sv
module gain_word_loader #(
  parameter int unsigned GAIN_W      = gwl_pkg::GAIN_W_DEF,
  parameter int unsigned SYNC_STAGES = gwl_pkg::SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_data,
  input  logic              ser_clk,
  input  logic              load_en_n,
  input  logic              pwr_dn_n,
  output logic [GAIN_W-1:0] gain_code,
  output logic              gain_upd,
  output logic              amp_en
);
  import gwl_pkg::*;

  logic [CTL_W-1:0] raw_vec;
  logic [CTL_W-1:0] sync_vec;
  logic [1:0]       lvl_vec;
  logic [1:0]       prev_vec;

  // Named internal events, observed by the checker
  logic              den_lvl;
  logic              sclk_lvl;
  logic              data_lvl;
  logic              sclk_rise;
  logic              sclk_fall;
  logic              den_rise;
  logic              master_q;
  logic [GAIN_W-1:0] slave_q;

  assign raw_vec = {pwr_dn_n, load_en_n, ser_clk, ser_data};

  gwl_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_vec),
    .q    (sync_vec)
  );

  assign data_lvl = sync_vec[IDX_DATA];
  assign sclk_lvl = sync_vec[IDX_SCLK];
  assign den_lvl  = sync_vec[IDX_DEN];
  assign amp_en   = sync_vec[IDX_PD];

  assign lvl_vec = {den_lvl, sclk_lvl};

  gwl_hist #(.W(2)) u_hist (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (lvl_vec),
    .prev (prev_vec)
  );

  assign sclk_rise = sclk_lvl & ~prev_vec[0];
  assign sclk_fall = ~sclk_lvl & prev_vec[0];
  assign den_rise  = den_lvl & ~prev_vec[1];

  gwl_shift #(.W(GAIN_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (sclk_rise & ~den_lvl),
    .adv     (sclk_fall & ~den_lvl),
    .din     (data_lvl),
    .master_q(master_q),
    .slave_q (slave_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_code <= '0;
      gain_upd  <= 1'b0;
    end else begin
      gain_upd <= den_rise;
      if (den_rise) gain_code <= slave_q;
    end
  end
endmodule

// File: rtl/gwl_chk.sv
module gwl_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         den_lvl,
  input logic         sclk_rise,
  input logic         sclk_fall,
  input logic         den_rise,
  input logic         master_q,
  input logic [W-1:0] slave_q,
  input logic [W-1:0] gain_code,
  input logic         gain_upd
);
  // R7
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gain_upd |=> !gain_upd);

  // R4
  gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !den_rise |=> $stable(gain_code));

  // R5
  gain_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    den_rise |=> (gain_code == $past(slave_q)) && gain_upd);

  // R6
  idle_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    den_lvl |=> $stable(slave_q) && $stable(master_q));

  // R3
  shift_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && !den_lvl) |=> slave_q == {$past(slave_q[W-2:0]), $past(master_q)});

  // R2
  capture_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !den_lvl) |=> $stable(slave_q));
endmodule

bind gain_word_loader gwl_chk #(.W(GAIN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .den_lvl  (den_lvl),
  .sclk_rise(sclk_rise),
  .sclk_fall(sclk_fall),
  .den_rise (den_rise),
  .master_q (master_q),
  .slave_q  (slave_q),
  .gain_code(gain_code),
  .gain_upd (gain_upd)
);

// File: tb/gain_word_loader_tb.sv
`timescale 1ns/1ps
module gain_word_loader_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_data = 1'b0;
  logic       ser_clk = 1'b0;
  logic       load_en_n = 1'b0;
  logic       pwr_dn_n = 1'b0;
  logic [7:0] gain_code;
  logic       gain_upd;
  logic       amp_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gain_word_loader u_dut (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .load_en_n(load_en_n), .pwr_dn_n(pwr_dn_n),
    .gain_code(gain_code), .gain_upd(gain_upd), .amp_en(amp_en)
  );

  // Reference model: input history queue, newest sample at index 0
  typedef struct packed { bit pd; bit den; bit sck; bit dat; } smp_t;
  smp_t hist[$];
  bit       m_master;
  bit [7:0] m_word;
  bit [7:0] m_gain;
  bit       m_upd;
  bit       m_amp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {};
      for (int i = 0; i < 4; i++) hist.push_front('0);
      m_master = 0; m_word = 0; m_gain = 0; m_upd = 0; m_amp = 0;
    end else begin
      smp_t seen, older;
      bit allow, new_master;
      bit [7:0] new_word;
      hist.push_front(smp_t'{pwr_dn_n, load_en_n, ser_clk, ser_data});
      if (hist.size() > 4) void'(hist.pop_back());
      seen  = hist[2];
      older = hist[3];
      allow = !seen.den;
      new_master = m_master;
      new_word   = m_word;
      if (allow && seen.sck && !older.sck) new_master = seen.dat;
      if (allow && !seen.sck && older.sck) new_word = {m_word[6:0], m_master};
      m_upd = seen.den && !older.den;
      if (m_upd) m_gain = m_word;
      m_master = new_master;
      m_word   = new_word;
      m_amp    = hist[1].pd;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(gain_code == m_gain, "R4/R5 model gain_code", gain_code, m_gain);
      chk(gain_upd == m_upd,   "R7 model gain_upd", gain_upd, m_upd);
      chk(amp_en == m_amp,     "R8 model amp_en", amp_en, m_amp);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    ser_data = b; idle(3);
    ser_clk = 1'b1; idle(3);
    ser_clk = 1'b0; idle(3);
  endtask

  task automatic send_word(input bit [7:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic commit();
    load_en_n = 1'b1; idle(6);
    load_en_n = 1'b0; idle(4);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    idle(3);
    // R9 reset state
    chk(gain_code == 8'h00, "R9 reset gain_code", gain_code, 0);
    chk(gain_upd == 1'b0,   "R9 reset gain_upd", gain_upd, 0);
    chk(amp_en == 1'b0,     "R9 reset amp_en", amp_en, 0);
    rst_n = 1'b1;
    idle(2);

    // R8 power enable latency
    pwr_dn_n = 1'b1; idle(1);
    chk(amp_en == 1'b0, "R8 amp_en after one edge", amp_en, 0);
    idle(1);
    chk(amp_en == 1'b1, "R8 amp_en after two edges", amp_en, 1);

    // R1 / R4 full word, held until commit
    send_word(8'hA5, 8);
    chk(gain_code == 8'h00, "R4 gain held while shifting", gain_code, 0);
    commit();
    chk(gain_code == 8'hA5, "R1 MSB-first word", gain_code, 8'hA5);

    // R5 / R7 commit latency and pulse alignment
    send_word(8'h3C, 8);
    load_en_n = 1'b1; idle(2);
    chk(gain_code == 8'hA5, "R5 not yet loaded after two edges", gain_code, 8'hA5);
    idle(1);
    chk(gain_code == 8'h3C, "R5 loaded after third edge", gain_code, 8'h3C);
    chk(gain_upd == 1'b1,   "R7 pulse with load", gain_upd, 1);
    idle(1);
    chk(gain_upd == 1'b0,   "R7 pulse one cycle", gain_upd, 0);
    idle(3);
    load_en_n = 1'b0; idle(4);

    // R6 clocks ignored while strobe high
    load_en_n = 1'b1; idle(4);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    load_en_n = 1'b0; idle(4);
    commit();
    chk(gain_code == 8'h3C, "R6 shifting inhibited", gain_code, 8'h3C);

    // R10 short word
    send_word(8'h05, 3);
    commit();
    chk(gain_code == 8'hE5, "R10 partial word loaded", gain_code, 8'hE5);

    // R2 capture without shift
    ser_data = 1'b1; idle(3);
    ser_clk = 1'b1; idle(3);
    load_en_n = 1'b1; idle(6);
    ser_clk = 1'b0; idle(4);
    load_en_n = 1'b0; idle(4);
    commit();
    chk(gain_code == 8'hE5, "R2 captured bit not shifted", gain_code, 8'hE5);

    // R3 single shift
    send_bit(1'b0);
    commit();
    chk(gain_code == 8'hCA, "R3 one shift", gain_code, 8'hCA);

    // R11 strobe rise coinciding with serial clock fall
    ser_data = 1'b1; idle(3);
    ser_clk = 1'b1; idle(3);
    ser_clk = 1'b0; load_en_n = 1'b1; idle(6);
    chk(gain_code == 8'hCA, "R11 coincident shift dropped", gain_code, 8'hCA);
    load_en_n = 1'b0; idle(4);
    commit();
    chk(gain_code == 8'hCA, "R11 word unchanged after recommit", gain_code, 8'hCA);

    // R1 random words, model compared every cycle
    for (int k = 0; k < 12; k++) begin
      bit [7:0] w;
      w = 8'($urandom);
      send_word(w, 8);
      commit();
      chk(gain_code == w, "R1 random word", gain_code, w);
    end

    pwr_dn_n = 1'b0; idle(2);
    chk(amp_en == 1'b0, "R8 amp disabled", amp_en, 0);

    finish_run();
  end
endmodule